// File: doc/BRIEF.md
# G.711 Companding Codec

The block sits between a linear sample path and a serial audio link that carries 8-bit companded samples. On the transmit side it compresses each signed linear sample into an 8-bit logarithmic code, either mu-law or A-law. The code goes out in the most significant byte of the outgoing data word. On the receive side it takes the code from the most significant byte of an incoming word and expands it back to a signed linear sample.

The law and the enable are static configuration inputs. Samples arrive one at a time on parallel ports, each marked by a valid strobe. Each direction answers exactly one cycle after its strobe, and its output register keeps its value until the next strobe. When companding is off, both directions copy words straight through with the same one-cycle latency.

Linear samples are SAMPLE_W bits wide, two's complement, with full scale in the top bits. The mu-law path uses the top 14 bits, which give a 13-bit magnitude. The A-law path uses the top 13 bits, which give a 12-bit magnitude. Expanded samples are returned on the same scale.

Top module: `g711_codec`

## Requirements
- R1: While rst_ni is low, tx_valid_o and rx_valid_o are 0, and tx_word_o and rx_lin_o are all zeros.
- R2: tx_valid_o equals tx_valid_i of the previous clock. tx_word_o changes only in the cycle after a cycle with tx_valid_i high, and holds its value otherwise.
- R3: rx_valid_o equals rx_valid_i of the previous clock. rx_lin_o changes only in the cycle after a cycle with rx_valid_i high, and holds its value otherwise.
- R4: With cmp_en_i = 0, tx_word_o becomes tx_lin_i and rx_lin_o becomes rx_word_i, one cycle after the strobe and bit for bit.
- R5: mu-law encode (law_sel_i = 0). Let x be tx_lin_i shifted right arithmetically by SAMPLE_W-14, and let n be 1 when x < 0. Take the magnitude |x| and clip it to 8158. Add 33 to get b. The segment s is the bit position of the highest 1 in b, minus 5. The mantissa m is bits [3:0] of b >> (s+1). The code is the bitwise inverse of {n, s[2:0], m[3:0]}.
- R6: A-law encode (law_sel_i = 1). Let x be tx_lin_i shifted right arithmetically by SAMPLE_W-13. The magnitude g is x when x >= 0 and -x-1 otherwise. The segment s is 0 when g < 32; otherwise s is the bit position of the highest 1 in g, minus 4. The mantissa m is bits [3:0] of g >> max(s,1). The code is {x>=0, s, m} XOR 8'h55, so only the even-numbered bits (0, 2, 4, 6) are inverted.
- R7: With companding on, the code sits in tx_word_o[SAMPLE_W-1:SAMPLE_W-8] and all lower bits are 0.
- R8: mu-law decode. The code c is rx_word_i[SAMPLE_W-1:SAMPLE_W-8] and u = ~c, with s = u[6:4] and m = u[3:0]. The value v is 4*(((2m+33) << s) - 33). The result rx_lin_o is v scaled left by SAMPLE_W-16, negated when u[7] = 1.
- R9: A-law decode. Let a = c XOR 8'h55, with s = a[6:4] and m = a[3:0]. The value v is 16m+8 when s = 0, and (16m+264) << (s-1) otherwise. The result rx_lin_o is v scaled left by SAMPLE_W-16, negated when a[7] = 0.
- R10: Boundary codes (SAMPLE_W = 16). mu-law encodes 0 to 8'hFF, the most positive sample to 8'h80 and the most negative sample to 8'h00. A-law encodes 0 to 8'hD5 and -1 to 8'h55. The mu-law code 8'hFF decodes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_en_i | input | 1 | 1: compand, 0: pass words through |
| law_sel_i | input | 1 | 0: mu-law, 1: A-law |
| tx_valid_i | input | 1 | Transmit sample strobe |
| tx_lin_i | input | SAMPLE_W | Linear sample to compress |
| tx_valid_o | output | 1 | Transmit word strobe |
| tx_word_o | output | SAMPLE_W | Outgoing word, code in the top byte |
| rx_valid_i | input | 1 | Receive word strobe |
| rx_word_i | input | SAMPLE_W | Incoming word, code in the top byte |
| rx_valid_o | output | 1 | Receive sample strobe |
| rx_lin_o | output | SAMPLE_W | Expanded linear sample |

## Verification
The only state is the two output stages, so a fault in that state shows at the ports one cycle after the strobe. A lost strobe, a stale hold value or a latency slip appears on the very next cycle. A fault in the segment search or the inversion masks gives a wrong code, and only for the samples that reach the faulty segment or bit. The bench therefore drives every one of the 256 codes through both expanders, and it drives random samples plus the full-scale and zero-crossing points through both compressors.

// File: rtl/g711_pkg.sv
package g711_pkg;
  typedef enum logic {LAW_MU = 1'b0, LAW_A = 1'b1} law_e;

  typedef struct packed {
    logic       neg;
    logic [2:0] seg;
    logic [3:0] mant;
  } g711_code_t;

  localparam int unsigned MU_BIAS  = 33;
  localparam int unsigned MU_CLIP  = 8158;
  localparam logic [7:0]  MU_INV   = 8'hFF;
  localparam logic [7:0]  A_INV    = 8'h55;
  localparam int unsigned CODE_W   = 8;
  localparam int unsigned MU_IN_W  = 14;
  localparam int unsigned A_IN_W   = 13;
  localparam int unsigned DEC_W    = 16;
endpackage

// File: rtl/g711_enc.sv
module g711_enc
  import g711_pkg::*;
(
  input  logic                law_i,
  input  logic [MU_IN_W-1:0]  smp_i,
  output logic [CODE_W-1:0]   code_o
);
  logic [MU_IN_W-1:0] mu_mag;
  logic [12:0]        mu_b;
  logic [12:0]        mu_sh;
  g711_code_t         mu_c;

  logic [A_IN_W-1:0]  a_x;
  logic [11:0]        a_mag;
  logic [11:0]        a_sh;
  g711_code_t         a_c;

  // mu-law: biased magnitude, segment = highest set bit above bit 4
  always_comb begin
    mu_mag = smp_i[MU_IN_W-1] ? (~smp_i + 1'b1) : smp_i;
    if (mu_mag > MU_IN_W'(MU_CLIP)) mu_mag = MU_IN_W'(MU_CLIP);
    mu_b = mu_mag[12:0] + 13'(MU_BIAS);
    mu_c.neg = smp_i[MU_IN_W-1];
    mu_c.seg = '0;
    for (int i = 0; i < 8; i++)
      if (mu_b[i+5]) mu_c.seg = 3'(i);
    mu_sh = mu_b >> (mu_c.seg + 4'd1);
    mu_c.mant = mu_sh[3:0];
  end

  // A-law: ones-complement magnitude, segments 0 and 1 share the step
  always_comb begin
    a_x   = smp_i[MU_IN_W-1:1];
    a_mag = a_x[A_IN_W-1] ? ~a_x[11:0] : a_x[11:0];
    a_c.neg = ~a_x[A_IN_W-1];
    a_c.seg = '0;
    for (int i = 1; i < 8; i++)
      if (a_mag[i+4]) a_c.seg = 3'(i);
    a_sh = (a_c.seg == 3'd0) ? (a_mag >> 1) : (a_mag >> a_c.seg);
    a_c.mant = a_sh[3:0];
  end

  always_comb begin
    if (law_e'(law_i) == LAW_A) code_o = a_c ^ A_INV;
    else                        code_o = mu_c ^ MU_INV;
  end
endmodule

// File: rtl/g711_dec.sv
module g711_dec
  import g711_pkg::*;
(
  input  logic                     law_i,
  input  logic [CODE_W-1:0]        code_i,
  output logic signed [DEC_W-1:0]  lin_o
);
  g711_code_t  mu_u, a_u;
  logic [16:0] mu_t, a_t;
  logic [15:0] mu_v, a_v;

  always_comb begin
    mu_u = ~code_i;
    mu_t = (17'({mu_u.mant, 3'b000}) + 17'd132) << mu_u.seg;
    mu_v = 16'(mu_t - 17'd132);

    a_u = code_i ^ A_INV;
    if (a_u.seg == 3'd0)
      a_t = 17'({a_u.mant, 4'b0000}) + 17'd8;
    else
      a_t = (17'({a_u.mant, 4'b0000}) + 17'd264) << (a_u.seg - 3'd1);
    a_v = a_t[15:0];

    if (law_e'(law_i) == LAW_A)
      lin_o = a_u.neg ? $signed(a_v) : -$signed(a_v);
    else
      lin_o = mu_u.neg ? -$signed(mu_v) : $signed(mu_v);
  end
endmodule

// File: rtl/g711_stage.sv
module g711_stage #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] data_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= data_i;
    end
  end
endmodule

// File: rtl/g711_codec.sv
module g711_codec
  import g711_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmp_en_i,
  input  logic                law_sel_i,
  input  logic                tx_valid_i,
  input  logic [SAMPLE_W-1:0] tx_lin_i,
  output logic                tx_valid_o,
  output logic [SAMPLE_W-1:0] tx_word_o,
  input  logic                rx_valid_i,
  input  logic [SAMPLE_W-1:0] rx_word_i,
  output logic                rx_valid_o,
  output logic [SAMPLE_W-1:0] rx_lin_o
);
  localparam int unsigned PAD_W   = SAMPLE_W - CODE_W;
  localparam int unsigned SCALE_W = SAMPLE_W - DEC_W;

  logic [CODE_W-1:0]       tx_code;
  logic signed [DEC_W-1:0] rx_lin16;
  logic [SAMPLE_W-1:0]     tx_next, rx_next, rx_scaled;

  g711_enc u_enc (
    .law_i  (law_sel_i),
    .smp_i  (tx_lin_i[SAMPLE_W-1 -: MU_IN_W]),
    .code_o (tx_code)
  );

  g711_dec u_dec (
    .law_i  (law_sel_i),
    .code_i (rx_word_i[SAMPLE_W-1 -: CODE_W]),
    .lin_o  (rx_lin16)
  );

  assign rx_scaled = SAMPLE_W'($signed(rx_lin16)) << SCALE_W;
  assign tx_next   = cmp_en_i ? {tx_code, {PAD_W{1'b0}}} : tx_lin_i;
  assign rx_next   = cmp_en_i ? rx_scaled : rx_word_i;

  g711_stage #(.W(SAMPLE_W)) u_tx_stage (
    .clk_i, .rst_ni,
    .valid_i (tx_valid_i), .data_i (tx_next),
    .valid_o (tx_valid_o), .data_o (tx_word_o)
  );

  g711_stage #(.W(SAMPLE_W)) u_rx_stage (
    .clk_i, .rst_ni,
    .valid_i (rx_valid_i), .data_i (rx_next),
    .valid_o (rx_valid_o), .data_o (rx_lin_o)
  );
endmodule

// File: rtl/g711_codec_chk.sv
module g711_codec_chk #(
  parameter int unsigned SAMPLE_W = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                cmp_en_i,
  input logic                law_sel_i,
  input logic                tx_valid_i,
  input logic [SAMPLE_W-1:0] tx_lin_i,
  input logic                tx_valid_o,
  input logic [SAMPLE_W-1:0] tx_word_o,
  input logic                rx_valid_i,
  input logic [SAMPLE_W-1:0] rx_word_i,
  input logic                rx_valid_o,
  input logic [SAMPLE_W-1:0] rx_lin_o
);
  a_r2_tx_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> tx_valid_o == $past(tx_valid_i));

  a_r2_tx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && !$past(tx_valid_i) |-> $stable(tx_word_o));

  a_r3_rx_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> rx_valid_o == $past(rx_valid_i));

  a_r3_rx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && !$past(rx_valid_i) |-> $stable(rx_lin_o));

  a_r4_tx_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(tx_valid_i) && !$past(cmp_en_i) |-> tx_word_o == $past(tx_lin_i));

  a_r4_rx_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(rx_valid_i) && !$past(cmp_en_i) |-> rx_lin_o == $past(rx_word_i));

  a_r7_pad_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(tx_valid_i) && $past(cmp_en_i) |-> tx_word_o[SAMPLE_W-9:0] == '0);

  a_r10_mu_silence: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(rx_valid_i) && $past(cmp_en_i) && !$past(law_sel_i)
    && ($past(rx_word_i[SAMPLE_W-1 -: 8]) == 8'hFF) |-> rx_lin_o == '0);
endmodule

bind g711_codec g711_codec_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmp_en_i   (cmp_en_i),
  .law_sel_i  (law_sel_i),
  .tx_valid_i (tx_valid_i),
  .tx_lin_i   (tx_lin_i),
  .tx_valid_o (tx_valid_o),
  .tx_word_o  (tx_word_o),
  .rx_valid_i (rx_valid_i),
  .rx_word_i  (rx_word_i),
  .rx_valid_o (rx_valid_o),
  .rx_lin_o   (rx_lin_o)
);

// File: tb/sim_g711_codec.sv
module sim_g711_codec;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic en, law;
  logic tx_v, rx_v;
  logic [SW-1:0] tx_lin, rx_word;
  logic tx_vo, rx_vo;
  logic [SW-1:0] tx_word, rx_lin;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  g711_codec #(.SAMPLE_W(SW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmp_en_i(en), .law_sel_i(law),
    .tx_valid_i(tx_v), .tx_lin_i(tx_lin), .tx_valid_o(tx_vo), .tx_word_o(tx_word),
    .rx_valid_i(rx_v), .rx_word_i(rx_word), .rx_valid_o(rx_vo), .rx_lin_o(rx_lin)
  );

  function automatic int mu_enc(input logic [15:0] s);
    int x, m, sg, mn, neg;
    x = int'($signed(s)) >>> 2;
    neg = (x < 0) ? 1 : 0;
    m = neg ? -x : x;
    if (m > 8158) m = 8158;
    m = m + 33;
    sg = 0;
    while ((m >> (sg + 6)) != 0) sg++;
    mn = (m >> (sg + 1)) & 15;
    return 255 - (neg * 128 + sg * 16 + mn);
  endfunction

  function automatic int a_enc(input logic [15:0] s);
    int x, m, sg, mn, pos;
    x = int'($signed(s)) >>> 3;
    pos = (x >= 0) ? 1 : 0;
    m = pos ? x : (-x - 1);
    sg = 0;
    while (m >= (32 << sg)) sg++;
    mn = (m >> ((sg == 0) ? 1 : sg)) & 15;
    return (pos * 128 + sg * 16 + mn) ^ 'h55;
  endfunction

  function automatic logic [15:0] mu_dec(input int c);
    int u, v;
    u = (~c) & 255;
    v = 4 * ((((2 * (u & 15)) + 33) << ((u >> 4) & 7)) - 33);
    if ((u & 128) != 0) v = -v;
    return 16'(v);
  endfunction

  function automatic logic [15:0] a_dec(input int c);
    int a, sg, v;
    a = c ^ 'h55;
    sg = (a >> 4) & 7;
    v = (sg == 0) ? (16 * (a & 15) + 8) : ((16 * (a & 15) + 264) << (sg - 1));
    if ((a & 128) == 0) v = -v;
    return 16'(v);
  endfunction

  task automatic chk(input string req, input logic [SW-1:0] act, input logic [SW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tx_xfer(input string req, input logic [SW-1:0] s);
    logic [SW-1:0] e;
    @(negedge clk);
    tx_v = 1'b1; tx_lin = s;
    @(negedge clk);
    tx_v = 1'b0; tx_lin = ~s;
    if (!en)      e = s;
    else if (law) e = {8'(a_enc(s)), 8'h00};
    else          e = {8'(mu_enc(s)), 8'h00};
    chk("R2 tx_valid_o", {15'd0, tx_vo}, 16'd1);
    chk(req, tx_word, e);
    @(negedge clk);
    chk("R2 tx hold", tx_word, e);
    chk("R2 tx_valid_o low", {15'd0, tx_vo}, 16'd0);
  endtask

  task automatic rx_xfer(input string req, input logic [SW-1:0] w);
    logic [SW-1:0] e;
    @(negedge clk);
    rx_v = 1'b1; rx_word = w;
    @(negedge clk);
    rx_v = 1'b0; rx_word = ~w;
    if (!en)      e = w;
    else if (law) e = a_dec(int'(w[15:8]));
    else          e = mu_dec(int'(w[15:8]));
    chk("R3 rx_valid_o", {15'd0, rx_vo}, 16'd1);
    chk(req, rx_lin, e);
    @(negedge clk);
    chk("R3 rx hold", rx_lin, e);
    chk("R3 rx_valid_o low", {15'd0, rx_vo}, 16'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7411));
    rst_n = 1'b0; en = 1'b1; law = 1'b0;
    tx_v = 1'b0; rx_v = 1'b0; tx_lin = '0; rx_word = '0;
    repeat (3) @(negedge clk);
    chk("R1 tx_valid_o", {15'd0, tx_vo}, 16'd0);
    chk("R1 tx_word_o", tx_word, 16'd0);
    chk("R1 rx_valid_o", {15'd0, rx_vo}, 16'd0);
    chk("R1 rx_lin_o", rx_lin, 16'd0);
    rst_n = 1'b1;

    // R10 boundary codes
    law = 1'b0;
    tx_xfer("R10 mu zero", 16'h0000);
    chk("R10 mu zero code", {8'h00, tx_word[15:8]}, 16'h00FF);
    tx_xfer("R10 mu max", 16'h7FFF);
    chk("R10 mu max code", {8'h00, tx_word[15:8]}, 16'h0080);
    tx_xfer("R10 mu min", 16'h8000);
    chk("R10 mu min code", {8'h00, tx_word[15:8]}, 16'h0000);
    rx_xfer("R10 mu FF decode", 16'hFF00);
    chk("R10 mu FF zero", rx_lin, 16'h0000);
    law = 1'b1;
    tx_xfer("R10 A zero", 16'h0000);
    chk("R10 A zero code", {8'h00, tx_word[15:8]}, 16'h00D5);
    tx_xfer("R10 A minus one", 16'hFFFF);
    chk("R10 A minus one code", {8'h00, tx_word[15:8]}, 16'h0055);
    tx_xfer("R6 A max", 16'h7FFF);
    tx_xfer("R6 A min", 16'h8000);

    // every code through both expanders
    for (int c = 0; c < 256; c++) begin
      law = 1'b0; rx_xfer("R8 mu decode", {8'(c), 8'($urandom)});
      law = 1'b1; rx_xfer("R9 A decode", {8'(c), 8'($urandom)});
    end

    // random samples, plus segment edges
    for (int i = 0; i < 300; i++) begin
      logic [15:0] s;
      s = 16'($urandom) >> ($urandom % 12);
      if ($urandom % 2) s = -s;
      law = 1'b0; tx_xfer("R5 R7 mu encode", s);
      law = 1'b1; tx_xfer("R6 R7 A encode", s);
    end
    for (int k = 0; k < 15; k++) begin
      law = 1'b0; tx_xfer("R5 mu edge", 16'((1 << k) - 1));
      law = 1'b1; tx_xfer("R6 A edge", 16'(-(1 << k)));
    end

    // bypass
    en = 1'b0;
    for (int i = 0; i < 40; i++) begin
      law = 1'($urandom);
      tx_xfer("R4 tx bypass", 16'($urandom));
      rx_xfer("R4 rx bypass", 16'($urandom));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule